// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Serial Shifter

This block is an eight-stage shift register that takes a whole byte in parallel and sends it out one bit at a time, and it can take new bits in serially at the other end. The stages move on a fast free-running system clock. Two slower control inputs, called tick A and tick B, decide when the register moves. They are treated as two clock inputs whose OR forms the register's clock. Each of them acts as an inhibit for the other. The register moves one place only when one tick input rises while the other stays low.

Both tick inputs first pass through a two-flop synchronizer. A small state machine then qualifies each rising edge of the combined clock. Its states are:
- `ST_QUIET`: both synchronized ticks are low.
- `ST_HELD`: the combined clock is high.
- `ST_LOADING`: the active-low load input is asserted.

Its transitions are:
- `QUIET->HELD`, which fires an advance when exactly one tick is high.
- `QUIET->HELD`, with no advance, when both ticks rise together.
- `HELD->QUIET`, when both ticks are low again.
- `any->LOADING`, when load goes low.
- `LOADING->QUIET` or `LOADING->HELD` on release, chosen by whether either tick is still high.

While load is low, the stages follow the parallel inputs on every system-clock cycle and all clocking is ignored. The last stage, and its complement, are the block's outputs.

Top module: `gated_piso_shift`

## Requirements
- R1: After reset every stage is 0, so `ser_out` is 0, `ser_out_n` is 1 and the qualifier is in `ST_QUIET`.
- R2: While `load_n` is 0, every stage follows `par_in` at each system clock edge. `ser_out` equals `par_in[7]` from the first edge that samples `load_n` low.
- R3: While `load_n` is 0, tick edges cause no shift. Releasing `load_n` while a tick is still high causes no shift either.
- R4: A rising `tick_a` with `tick_b` low advances the register by one place. So does a rising `tick_b` with `tick_a` low.
- R5: A rising tick while the other tick is high causes no advance. Neither does the later fall of the other tick.
- R6: When both ticks rise in the same sampled cycle, no advance occurs.
- R7: Each qualifying rise gives exactly one advance. Holding the tick high, or letting it fall, gives no further advance.
- R8: On an advance, stage i takes stage i-1. After a load, the output therefore presents `par_in[7]`, then 6, and so on down to 0, one bit per advance.
- R9: On an advance, `ser_in` enters stage 0. After eight advances, the serial bits come out in the order they went in.
- R10: `ser_out_n` is always the complement of `ser_out`.
- R11: A tick change applied before system edge k moves `ser_out` at edge k+2 (the third edge counting k itself), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_a | input | 1 | First register clock input |
| tick_b | input | 1 | Second register clock input, and inhibit for the first |
| load_n | input | 1 | Active-low parallel load, level sensitive |
| par_in | input | 8 | Parallel data, bit 7 leaves first |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Last stage |
| ser_out_n | output | 1 | Complement of the last stage |

## Verification
A tick change passes through two synchronizer flops and then the stage register. Its effect on `ser_out` therefore shows up on the third rising edge after the change. The bench checks one case both after two edges, expecting no change, and after three edges, expecting the change. A load shows up after one edge. The bench drives every input on a falling edge and samples only on later falling edges. After each tick change it waits at least four edges before it compares against its own byte model. A result is therefore never read while it is still changing.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_HELD    = 2'd1,
        ST_LOADING = 2'd2
    } qual_state_t;

    localparam int TICK_LINES = 2;

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_flop
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/piso_edge_fsm.sv
module piso_edge_fsm
    import piso_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_n,
    input  logic [TICK_LINES-1:0] ticks,
    output logic                  advance
);

    qual_state_t state_q, state_d;
    logic        any_high;
    logic        one_high;

    assign any_high = |ticks;
    assign one_high = ($countones(ticks) == 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (!load_n)       state_d = ST_LOADING;
                else if (any_high) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (!load_n)        state_d = ST_LOADING;
                else if (!any_high) state_d = ST_QUIET;
            end
            ST_LOADING: begin
                if (load_n) state_d = any_high ? ST_HELD : ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        advance = 1'b0;
        unique case (state_q)
            ST_QUIET:   advance = load_n && one_high;
            ST_HELD:    advance = 1'b0;
            ST_LOADING: advance = 1'b0;
            default:    advance = 1'b0;
        endcase
    end

    assert_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> ($countones(ticks) == 1));

    assert_load_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> !advance);

    assert_single_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> !advance);

    assert_both_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ticks == 2'b11) |-> !advance);

endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             advance,
    output logic             last_bit
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stage_q <= '0;
        else if (!load_n) stage_q <= par_in;
        else if (advance) stage_q <= {stage_q[TOP-1:0], ser_in};
    end

    assign last_bit = stage_q[TOP];

    assert_load_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (last_bit == $past(par_in[TOP])));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !advance) |=> $stable(last_bit));

    assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && advance) |=> (last_bit == $past(stage_q[TOP-1])));

endmodule

// File: rtl/gated_piso_shift.sv
module gated_piso_shift
    import piso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             ser_out_n
);

    logic [TICK_LINES-1:0] ticks_sync;
    logic                  advance;
    logic                  last_bit;

    piso_sync #(.WIDTH(TICK_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({tick_b, tick_a}),
        .dout  (ticks_sync)
    );

    piso_edge_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .ticks   (ticks_sync),
        .advance (advance)
    );

    piso_stages #(.WIDTH(WIDTH)) u_stages (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .par_in   (par_in),
        .ser_in   (ser_in),
        .advance  (advance),
        .last_bit (last_bit)
    );

    assign ser_out   = last_bit;
    assign ser_out_n = ~last_bit;

    assert_complement_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_n != ser_out);

endmodule

// File: tb/gated_piso_shift_test.sv
module gated_piso_shift_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_a = 1'b0;
    logic       tick_b = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] par_in = 8'h00;
    logic       ser_in = 1'b0;
    logic       ser_out;
    logic       ser_out_n;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model = 8'h00;

    always #2.5 clk = ~clk;

    gated_piso_shift uut (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .load_n(load_n), .par_in(par_in), .ser_in(ser_in),
        .ser_out(ser_out), .ser_out_n(ser_out_n)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check(ser_out == model[7], req, ser_out, model[7]);
        check(ser_out_n == ~model[7], "R10", ser_out_n, ~model[7]);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] v);
        @(negedge clk);
        par_in = v; load_n = 1'b0;
        wait_n(1);
        model = v;
        check_out("R2");
        @(negedge clk) load_n = 1'b1;
        wait_n(2);
    endtask

    // which: 0 = tick_a, 1 = tick_b; expect_adv tells whether to shift the model
    task automatic pulse(input int which, input logic sval, input logic expect_adv, input string req);
        @(negedge clk);
        ser_in = sval;
        if (which == 0) tick_a = 1'b1; else tick_b = 1'b1;
        wait_n(4);
        if (expect_adv) model = {model[6:0], sval};
        check_out(req);
        if (which == 0) tick_a = 1'b0; else tick_b = 1'b0;
        wait_n(4);
        check_out("R7");
    endtask

    task automatic t_reset();
        wait_n(1);
        model = 8'h00;
        check_out("R1");
    endtask

    task automatic t_load_track();
        @(negedge clk);
        load_n = 1'b0; par_in = 8'h80;
        wait_n(1);
        check(ser_out == 1'b1, "R2", ser_out, 1);
        par_in = 8'h7F;
        wait_n(1);
        check(ser_out == 1'b0, "R2", ser_out, 0);
        par_in = 8'hC3;
        wait_n(1);
        model = 8'hC3;
        check_out("R2");
        load_n = 1'b1;
        wait_n(2);
    endtask

    task automatic t_shift_out(input int which);
        logic [7:0] v;
        v = 8'($urandom);
        do_load(v);
        for (int i = 0; i < 8; i++) begin
            check(ser_out == v[7-i], "R8", ser_out, v[7-i]);
            pulse(which, 1'b0, 1'b1, "R4");
        end
    endtask

    task automatic t_latency();
        do_load(8'hA5);
        @(negedge clk) tick_a = 1'b1;
        wait_n(2);
        check(ser_out == 1'b1, "R11", ser_out, 1);
        wait_n(1);
        check(ser_out == 1'b0, "R11", ser_out, 0);
        model = 8'h4A;
        wait_n(2);
        check_out("R7");
        tick_a = 1'b0;
        wait_n(4);
        check_out("R7");
    endtask

    task automatic t_inhibit();
        do_load(8'h96);
        @(negedge clk) tick_b = 1'b1;
        wait_n(4);
        model = {model[6:0], 1'b0};
        check_out("R4");
        pulse(0, 1'b1, 1'b0, "R5");
        @(negedge clk) tick_b = 1'b0;
        wait_n(4);
        check_out("R5");
        pulse(0, 1'b1, 1'b1, "R4");
    endtask

    task automatic t_both();
        do_load(8'h5A);
        @(negedge clk) begin tick_a = 1'b1; tick_b = 1'b1; end
        wait_n(5);
        check_out("R6");
        tick_a = 1'b0;
        wait_n(4);
        check_out("R6");
        tick_b = 1'b0;
        wait_n(4);
        check_out("R6");
    endtask

    task automatic t_load_blocks();
        @(negedge clk);
        par_in = 8'h3C; load_n = 1'b0;
        tick_a = 1'b1;
        wait_n(4);
        tick_a = 1'b0;
        wait_n(4);
        tick_b = 1'b1;
        wait_n(4);
        model = 8'h3C;
        check_out("R3");
        load_n = 1'b1;
        wait_n(4);
        check_out("R3");
        tick_b = 1'b0;
        wait_n(4);
        check_out("R3");
        pulse(0, 1'b0, 1'b1, "R3");
    endtask

    task automatic t_serial_in();
        logic [7:0] s;
        s = 8'($urandom) ^ 8'h69;
        do_load(8'h00);
        for (int i = 0; i < 8; i++) pulse(i % 2, s[i], 1'b1, "R9");
        for (int i = 0; i < 8; i++) begin
            check(ser_out == s[i], "R9", ser_out, s[i]);
            pulse(0, 1'b0, 1'b1, "R9");
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        wait_n(2);
        model = 8'h00;
        check_out("R1");
        t_load_track();
        t_shift_out(0);
        t_shift_out(1);
        t_latency();
        t_inhibit();
        t_both();
        t_load_blocks();
        t_serial_in();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule